// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Error Signalling

This block is an asynchronous serial port for a smart-card style link. It sends one byte at a time from a single-entry transmit holding register and captures received bytes into a single-entry receive register. Every character is framed as a low start bit, eight data bits, an even-parity bit and a configurable run of high stop bits (at least two). Each bit lasts sixteen oversampling ticks, and every received bit is decided by a two-of-three vote of ticks 7, 8 and 9. The bit order and the polarity can be switched between a direct convention and an inverse convention.

The oversampling tick comes from a divider that counts either system clocks or rising edges of an external clock input. When the receiver finds a parity error, it answers by pulling its transmit line low for one bit time, the way a card link reports a bad character. When the transmitter finishes a character, it samples the receive line at the moment of its completion interrupt, which tells it whether the far end reported an error. Receive status covers overrun, framing and parity, and one combined flag ORs the three together.

Top module: `sc_uart`

## Requirements
- R1: One bit lasts 16×(div_n+1) ticks of the selected source. With clk_sel=0 the source is clk. With clk_sel=1 the source is each rising edge of ext_clk, counted after synchronisation.
- R2: A pulse on tx_wr stores tx_wdata and clears tx_empty. A character starts only while tx_en=1 and tx_empty=0, and starting it sets tx_empty back to 1.
- R3: txd idles high and sends a 0 start bit, eight data bits, a parity bit, then STOP_BITS high stop bits. The parity bit is chosen so that the logical data bits plus the parity bit hold an even number of ones. With inverse=0, data goes LSB first at true levels. With inverse=1, data goes MSB first, and the data and parity levels are complemented.
- R4: tx_irq is a one-cycle pulse, given once per character at the end of the first stop bit.
- R5: Reception begins only while rx_en=1, on a high-to-low change of rxd. If the start bit votes high, the character is dropped with no side effect. With rx_en=0, nothing is captured.
- R6: When a character completes, its byte appears on rx_rdata, using the same bit-order and polarity convention as R3. At the same time rx_full goes to 1 and rx_irq pulses for one cycle, near the middle of the last stop bit.
- R7: If a received character fails the even-parity rule, par_err=1 is reported with it. txd is also driven low for one bit time, starting half a bit after the parity bit ends.
- R8: frm_err=1 is reported with a character when any of its stop bits votes low.
- R9: If rx_full is still 1 when a new character reaches the bit before its last stop bit, ovr_err goes to 1. That character then gives no rx_irq, and the content of rx_rdata is not defined.
- R10: err_sum equals ovr_err OR frm_err OR par_err.
- R11: When tx_irq fires, tx_nack takes the complement of the synchronised rxd level. tx_nack is cleared when the next character starts.
- R12: A pulse on rx_rd clears rx_full and ovr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 1 | Divider source: 0 = clk, 1 = ext_clk |
| ext_clk | input | 1 | External divider source |
| div_n | input | 8 | Divider setting n |
| inverse | input | 1 | 1 = inverse convention, 0 = direct |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register is free |
| tx_irq | output | 1 | Character sent (pulse) |
| tx_nack | output | 1 | Far end reported an error on the last character |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_rdata | output | 8 | Received byte |
| rx_full | output | 1 | Receive register holds unread data |
| rx_irq | output | 1 | Character received (pulse) |
| par_err | output | 1 | Parity error on the last character |
| frm_err | output | 1 | Framing error on the last character |
| ovr_err | output | 1 | Overrun occurred |
| err_sum | output | 1 | Any error flag set |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
rx_irq is due roughly (10+STOP_BITS−0.5) bit times after the start edge, plus about three clock cycles for synchronisation and detection. The parity-error low on txd spans from 10.5 to 11.5 bit times after the start edge, and tx_irq comes about 11 bit times after the first transmitted falling edge. Receive results are compared by a monitor that pops the scoreboard whenever rx_irq occurs, so a drift of a few cycles cannot misalign a comparison. Line levels are sampled at bit centres, and the bench waits whole bit times past each due point before it reads sticky flags.

// File: rtl/sc_uart_pkg.sv
// Shared constants and helpers for the smart-card UART.
// Assumes a fixed 16x oversampling and a three-point vote around mid-bit.
package sc_uart_pkg;
    localparam int OSR   = 16;
    localparam int OSR_W = $clog2(OSR);
    localparam int SMP_A = 7;
    localparam int SMP_B = 8;
    localparam int SMP_C = 9;

    // Two-of-three vote.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/sc_baud_gen.sv
// Oversampling tick generator.
// Emits one-cycle os_tick every (div_n+1) source ticks; the source is clk
// itself or a synchronised rising edge of ext_clk. Assumes ext_clk is slower
// than clk/2.
module sc_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] div_n,
    output logic             os_tick
);
    logic [2:0]       ext_q;
    logic [DIV_W-1:0] cnt;
    logic             src_tick;

    // Synchronise the external source and keep one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= {ext_q[1:0], ext_clk};
    end

    assign src_tick = src_sel ? (ext_q[1] & ~ext_q[2]) : 1'b1;

    // Count source ticks and pulse os_tick when the count reaches div_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            os_tick <= 1'b0;
        end else begin
            os_tick <= 1'b0;
            if (src_tick) begin
                if (cnt == div_n) begin
                    cnt     <= '0;
                    os_tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: with a divider above zero, ticks are never back to back.
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && div_n != '0) |=> !os_tick);
endmodule

// File: rtl/sc_uart_tx.sv
// Transmit engine: one holding register plus a frame shift register.
// Builds start/data/parity/stop levels for the direct or inverse convention,
// pulses tx_irq at the end of the first stop bit and samples the receive
// line there for a far-end error. Assumes STOP_BITS >= 2.
module sc_uart_tx
    import sc_uart_pkg::*;
#(
    parameter int DW        = 8,
    parameter int STOP_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          tx_en,
    input  logic          inverse,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          rxd_s,
    output logic          tx_line,
    output logic          tx_empty,
    output logic          tx_irq,
    output logic          tx_nack
);
    localparam int NBITS   = DW + 2 + STOP_BITS;
    localparam int BI_W    = $clog2(NBITS);
    localparam int ACK_BIT = DW + 2;

    logic [DW-1:0]    hold_q;
    logic [NBITS-1:0] frame_d, shreg;
    logic [BI_W-1:0]  bi;
    logic [OSR_W-1:0] sc;
    logic             busy;

    // Assemble the line levels of a whole character from the held byte.
    always_comb begin
        frame_d    = '1;
        frame_d[0] = 1'b0;
        for (int i = 0; i < DW; i++)
            frame_d[1+i] = inverse ? ~hold_q[DW-1-i] : hold_q[i];
        frame_d[DW+1] = inverse ? ~(^hold_q) : (^hold_q);
    end

    // Holding register, start decision, bit stepping and far-end error sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            shreg    <= '1;
            bi       <= '0;
            sc       <= '0;
            busy     <= 1'b0;
            tx_empty <= 1'b1;
            tx_irq   <= 1'b0;
            tx_nack  <= 1'b0;
        end else begin
            tx_irq <= 1'b0;
            if (!busy && tx_en && !tx_empty) begin
                shreg    <= frame_d;
                busy     <= 1'b1;
                bi       <= '0;
                sc       <= '0;
                tx_empty <= 1'b1;
                tx_nack  <= 1'b0;
            end else if (busy && os_tick) begin
                sc <= sc + 1'b1;
                if (sc == OSR_W'(OSR - 1)) begin
                    if (bi == BI_W'(ACK_BIT)) begin
                        tx_irq  <= 1'b1;
                        tx_nack <= ~rxd_s;
                    end
                    if (bi == BI_W'(NBITS - 1)) busy <= 1'b0;
                    else                        bi   <= bi + 1'b1;
                end
            end
            if (load) begin
                hold_q   <= load_data;
                tx_empty <= 1'b0;
            end
        end
    end

    assign tx_line = busy ? shreg[bi] : 1'b1;

    // R2: a character starts only when enabled and the holding register is full.
    a_r2_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(tx_en) && !$past(tx_empty)));
    // R4: the completion pulse lasts one cycle.
    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);
    // R4: the completion pulse falls inside a character (guard stop bit follows).
    a_r4_irq_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> busy);
endmodule

// File: rtl/sc_uart_rx.sv
// Receive engine: start detection, 3-point voting, deframing, error status
// and the low error signal answered on a parity failure.
// Assumes rxd_s is already synchronised and STOP_BITS >= 2.
module sc_uart_rx
    import sc_uart_pkg::*;
#(
    parameter int DW        = 8,
    parameter int STOP_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_en,
    input  logic          inverse,
    input  logic          rxd_s,
    input  logic          rd,
    output logic [DW-1:0] data_q,
    output logic          rx_full,
    output logic          rx_irq,
    output logic          par_err,
    output logic          frm_err,
    output logic          ovr_err,
    output logic          err_drv
);
    localparam int NBITS      = DW + 2 + STOP_BITS;
    localparam int BI_W       = $clog2(NBITS);
    localparam int PAR_BIT    = DW + 1;
    localparam int FIRST_STOP = DW + 2;
    localparam int LAST_BIT   = NBITS - 1;

    logic [BI_W-1:0]  bi;
    logic [OSR_W-1:0] sc;
    logic [DW-1:0]    sh;
    logic             active, rxd_d, s_a, s_b;
    logic             par_acc, par_bad, stop_bad, ovr_hit;
    logic             vote, bval;

    assign vote = maj3(s_a, s_b, rxd_s);
    assign bval = inverse ? ~vote : vote;

    // Frame sequencer: detect, sample, assemble, check and hand over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bi <= '0; sc <= '0; sh <= '0; data_q <= '0;
            active <= 1'b0; rxd_d <= 1'b1; s_a <= 1'b1; s_b <= 1'b1;
            par_acc <= 1'b0; par_bad <= 1'b0; stop_bad <= 1'b0; ovr_hit <= 1'b0;
            rx_full <= 1'b0; rx_irq <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
            ovr_err <= 1'b0; err_drv <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            rxd_d  <= rxd_s;
            if (rd) begin
                rx_full <= 1'b0;
                ovr_err <= 1'b0;
            end
            if (!active) begin
                err_drv <= 1'b0;
                if (rx_en && rxd_d && !rxd_s) begin
                    active   <= 1'b1;
                    sc       <= '0;
                    bi       <= '0;
                    par_acc  <= 1'b0;
                    par_bad  <= 1'b0;
                    stop_bad <= 1'b0;
                    ovr_hit  <= 1'b0;
                end
            end else if (!rx_en) begin
                active  <= 1'b0;
                err_drv <= 1'b0;
            end else if (os_tick) begin
                sc <= sc + 1'b1;
                if (sc == OSR_W'(SMP_A)) s_a <= rxd_s;
                if (sc == OSR_W'(SMP_B)) s_b <= rxd_s;
                if (sc == OSR_W'(SMP_A) && bi == BI_W'(FIRST_STOP) && par_bad)
                    err_drv <= 1'b1;
                if (sc == OSR_W'(SMP_A) && bi == BI_W'(FIRST_STOP + 1))
                    err_drv <= 1'b0;
                if (sc == OSR_W'(OSR - 1)) bi <= bi + 1'b1;
                if (sc == OSR_W'(SMP_C)) begin
                    if (bi == '0) begin
                        if (vote) active <= 1'b0;
                    end else if (bi <= BI_W'(DW)) begin
                        sh      <= inverse ? {sh[DW-2:0], bval} : {bval, sh[DW-1:1]};
                        par_acc <= par_acc ^ bval;
                    end else if (bi == BI_W'(PAR_BIT)) begin
                        par_bad <= par_acc ^ bval;
                    end else if (!vote) begin
                        stop_bad <= 1'b1;
                    end
                    if (bi == BI_W'(LAST_BIT - 1) && rx_full && !rd) begin
                        ovr_hit <= 1'b1;
                        ovr_err <= 1'b1;
                    end
                    if (bi == BI_W'(LAST_BIT)) begin
                        active <= 1'b0;
                        if (!ovr_hit) begin
                            data_q  <= sh;
                            rx_full <= 1'b1;
                            rx_irq  <= 1'b1;
                            par_err <= par_bad;
                            frm_err <= stop_bad | ~vote;
                        end
                    end
                end
            end
        end
    end

    // R5: a character is only entered while reception is enabled.
    a_r5_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(rx_en));
    // R7: the error signal is driven only within a character.
    a_r7_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        err_drv |-> active);
    // R9: overrun can only be raised while unread data is held.
    a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> $past(rx_full));
    // R12: a read empties the register unless a character lands at once.
    a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (!rx_full || rx_irq));
endmodule

// File: rtl/sc_uart.sv
// Smart-card UART top: divider, receive synchroniser, transmit and receive
// engines. The receive engine's error signal is ANDed onto txd (active low).
// Assumes a half-duplex link: software keeps rx_en low while sending.
module sc_uart #(
    parameter int DIV_W     = 8,
    parameter int DW        = 8,
    parameter int STOP_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_sel,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] div_n,
    input  logic             inverse,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_wdata,
    output logic             tx_empty,
    output logic             tx_irq,
    output logic             tx_nack,
    input  logic             rx_rd,
    output logic [DW-1:0]    rx_rdata,
    output logic             rx_full,
    output logic             rx_irq,
    output logic             par_err,
    output logic             frm_err,
    output logic             ovr_err,
    output logic             err_sum,
    input  logic             rxd,
    output logic             txd
);
    logic [1:0] rxd_q;
    logic       os_tick, tx_line, err_drv;

    // Two-stage synchroniser for the serial input, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_q <= 2'b11;
        else        rxd_q <= {rxd_q[0], rxd};
    end

    sc_baud_gen #(.DIV_W(DIV_W)) i_baud (
        .clk(clk), .rst_n(rst_n), .src_sel(clk_sel), .ext_clk(ext_clk),
        .div_n(div_n), .os_tick(os_tick)
    );

    sc_uart_tx #(.DW(DW), .STOP_BITS(STOP_BITS)) i_tx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .tx_en(tx_en),
        .inverse(inverse), .load(tx_wr), .load_data(tx_wdata), .rxd_s(rxd_q[1]),
        .tx_line(tx_line), .tx_empty(tx_empty), .tx_irq(tx_irq), .tx_nack(tx_nack)
    );

    sc_uart_rx #(.DW(DW), .STOP_BITS(STOP_BITS)) i_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .inverse(inverse), .rxd_s(rxd_q[1]), .rd(rx_rd), .data_q(rx_rdata),
        .rx_full(rx_full), .rx_irq(rx_irq), .par_err(par_err), .frm_err(frm_err),
        .ovr_err(ovr_err), .err_drv(err_drv)
    );

    assign txd     = tx_line & ~err_drv;
    assign err_sum = ovr_err | frm_err | par_err;
endmodule

// File: tb/test_sc_uart.sv
// Scoreboard bench: driver tasks queue expected bytes, monitors pop them as
// the design completes characters.
module test_sc_uart;
    typedef struct packed { logic [7:0] d; logic p; logic f; } rx_exp_t;
    typedef struct packed { logic [7:0] d; logic inv; logic nack; } tx_exp_t;

    logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
    always #2 clk = ~clk;
    initial forever #8 ext_clk = ~ext_clk;

    logic       clk_sel = 1'b0, inverse = 1'b0, tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0;
    logic [7:0] div_n = 8'd1, tx_wdata = 8'd0;
    logic       rd_auto = 1'b0, rd_man = 1'b0, rxd_drv = 1'b1, rxd_nack = 1'b1;
    logic       rx_rd, rxd;
    logic       tx_empty, tx_irq, tx_nack, rx_full, rx_irq, par_err, frm_err, ovr_err, err_sum, txd;
    logic [7:0] rx_rdata;

    assign rx_rd = rd_auto | rd_man;
    assign rxd   = rxd_drv & rxd_nack;

    int  bitc = 32, checks = 0, fails = 0, tx_done = 0, txirq_cnt = 0;
    bit  auto_read = 1'b1, tx_mon_on = 1'b0, finished = 1'b0;
    rx_exp_t rxq[$];
    tx_exp_t txq[$];

    sc_uart i_sc_uart (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk), .div_n(div_n),
        .inverse(inverse), .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_empty(tx_empty), .tx_irq(tx_irq), .tx_nack(tx_nack), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_irq(rx_irq), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .err_sum(err_sum), .rxd(rxd), .txd(txd)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Drive one character on rxd; queue its expectation when one is due.
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit expect_it);
        logic [11:0] lv;
        logic p;
        p     = (^d) ^ bad_par;
        lv[0] = 1'b0;
        for (int i = 0; i < 8; i++) lv[1+i] = inverse ? ~d[7-i] : d[i];
        lv[9]  = inverse ? ~p : p;
        lv[10] = ~bad_stop;
        lv[11] = 1'b1;
        if (expect_it) rxq.push_back(rx_exp_t'{d, bad_par, bad_stop});
        for (int k = 0; k < 12; k++) begin
            rxd_drv = lv[k];
            repeat (bitc) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (2 * bitc) @(negedge clk);
    endtask

    task automatic load_tx(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    // Wait for the tx monitor to finish a character, then check side results.
    task automatic wait_tx(input int n0, input int irq0, input bit nack);
        int guard;
        guard = 0;
        while (tx_done == n0 && guard < 20 * bitc) begin
            @(negedge clk); guard++;
        end
        chk(tx_done > n0, "R3 character seen on txd", tx_done, n0 + 1);
        repeat (2 * bitc) @(negedge clk);
        chk(txirq_cnt == irq0 + 1, "R4 one tx_irq per character", txirq_cnt, irq0 + 1);
        chk(tx_nack == nack, "R11 tx_nack", tx_nack, nack);
        chk(tx_empty == 1'b1, "R2 empty after start", tx_empty, 1);
    endtask

    task automatic send_tx(input logic [7:0] d, input bit inv, input bit nack);
        int n0, irq0;
        inverse = inv;
        n0 = tx_done; irq0 = txirq_cnt;
        txq.push_back(tx_exp_t'{d, inv, nack});
        load_tx(d);
        wait_tx(n0, irq0, nack);
    endtask

    // Receive scoreboard monitor: pop and compare on every rx_irq.
    initial begin : rx_monitor
        rx_exp_t e;
        forever begin
            @(negedge clk);
            rd_auto = 1'b0;
            if (rx_irq) begin
                if (rxq.size() == 0) begin
                    chk(1'b0, "R9 unexpected rx_irq", rx_rdata, 0);
                end else begin
                    e = rxq.pop_front();
                    chk(rx_rdata == e.d, "R6 rx_rdata", rx_rdata, e.d);
                    chk(par_err == e.p, "R7 par_err", par_err, e.p);
                    chk(frm_err == e.f, "R8 frm_err", frm_err, e.f);
                    chk(err_sum == (e.p | e.f), "R10 err_sum", err_sum, e.p | e.f);
                    chk(rx_full == 1'b1, "R6 rx_full", rx_full, 1);
                end
                if (auto_read) rd_auto = 1'b1;
            end
        end
    end

    // Transmit monitor: decode txd at bit centres, inject the far-end error.
    initial begin : tx_monitor
        logic prev;
        logic [9:0] lv;
        logic [7:0] dd;
        logic p;
        tx_exp_t e;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (tx_mon_on && prev && !txd) begin
                if (txq.size() == 0) begin
                    chk(1'b0, "R2 unexpected character", 0, 1);
                    e = '0;
                end else begin
                    e = txq.pop_front();
                end
                repeat (bitc / 2) @(negedge clk);
                chk(txd == 1'b0, "R3 start bit", txd, 0);
                for (int k = 0; k < 10; k++) begin
                    repeat (bitc) @(negedge clk);
                    lv[k] = txd;
                end
                if (e.nack) begin
                    rxd_nack = 1'b0;
                    repeat (bitc) @(negedge clk);
                    rxd_nack = 1'b1;
                end
                for (int i = 0; i < 8; i++) dd[i] = e.inv ? ~lv[7-i] : lv[i];
                p = e.inv ? ~lv[8] : lv[8];
                chk(dd == e.d, "R3 data bits", dd, e.d);
                chk(((^dd) ^ p) == 1'b0, "R3 even parity", p, ^dd);
                chk(lv[9] == 1'b1, "R3 stop bit", lv[9], 1);
                tx_done++;
            end
            prev = txd;
        end
    end

    always @(negedge clk) if (tx_irq) txirq_cnt++;

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin : main
        int n0, irq0;
        bit held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd == 1'b1, "R3 idle high after reset", txd, 1);
        chk(tx_empty == 1'b1, "R2 empty after reset", tx_empty, 1);
        chk(rx_full == 1'b0, "R6 rx_full after reset", rx_full, 0);
        chk(err_sum == 1'b0, "R10 err_sum after reset", err_sum, 0);
        chk(tx_irq == 1'b0 && rx_irq == 1'b0, "R4 no irq after reset", {tx_irq, rx_irq}, 0);

        rx_en = 1'b1;
        // R6 direct convention, two patterns.
        send_frame(8'hA5, 0, 0, 1);
        send_frame(8'h3C, 0, 0, 1);
        // R1 larger internal divider.
        div_n = 8'd3; bitc = 64;
        send_frame(8'h5E, 0, 0, 1);
        div_n = 8'd1; bitc = 32;
        // R3/R6 inverse convention.
        inverse = 1'b1;
        send_frame(8'h5A, 0, 0, 1);
        send_frame(8'h0F, 0, 0, 1);
        inverse = 1'b0;
        // R7 parity error and the low error signal.
        fork
            send_frame(8'h33, 1, 0, 1);
            begin
                repeat (11 * bitc) @(negedge clk);
                chk(txd == 1'b0, "R7 error signal low", txd, 0);
                repeat (2 * bitc) @(negedge clk);
                chk(txd == 1'b1, "R7 error signal released", txd, 1);
            end
        join
        send_frame(8'h44, 0, 0, 1);
        // R8 low first stop bit.
        send_frame(8'h99, 0, 1, 1);
        send_frame(8'h66, 0, 0, 1);
        // R5 short glitch rejected.
        @(negedge clk); rxd_drv = 1'b0;
        repeat (4) @(negedge clk); rxd_drv = 1'b1;
        repeat (2 * bitc) @(negedge clk);
        chk(rx_full == 1'b0, "R5 glitch ignored", rx_full, 0);
        send_frame(8'h77, 0, 0, 1);
        // R5 reception disabled.
        rx_en = 1'b0;
        send_frame(8'h81, 0, 0, 0);
        chk(rx_full == 1'b0, "R5 disabled receive ignored", rx_full, 0);
        rx_en = 1'b1;
        // R9 overrun, R12 read clears.
        auto_read = 1'b0;
        send_frame(8'h18, 0, 0, 1);
        send_frame(8'h24, 0, 0, 0);
        chk(ovr_err == 1'b1, "R9 ovr_err", ovr_err, 1);
        chk(err_sum == 1'b1, "R10 err_sum on overrun", err_sum, 1);
        chk(rx_full == 1'b1, "R9 still full", rx_full, 1);
        @(negedge clk); rd_man = 1'b1;
        @(negedge clk); rd_man = 1'b0;
        @(negedge clk);
        chk(rx_full == 1'b0, "R12 rx_full cleared", rx_full, 0);
        chk(ovr_err == 1'b0, "R12 ovr_err cleared", ovr_err, 0);
        auto_read = 1'b1;
        // R1 external source.
        clk_sel = 1'b1; div_n = 8'd0; bitc = 64;
        send_frame(8'hC3, 0, 0, 1);
        clk_sel = 1'b0; div_n = 8'd1; bitc = 32;
        chk(rxq.size() == 0, "R6 all characters received", rxq.size(), 0);

        // Transmit side, half-duplex.
        rx_en = 1'b0; tx_en = 1'b1; tx_mon_on = 1'b1;
        send_tx(8'h96, 0, 0);
        send_tx(8'h2D, 1, 0);
        send_tx(8'hE1, 0, 1);
        send_tx(8'h12, 0, 0);
        // R2 hold while disabled.
        tx_en = 1'b0; inverse = 1'b0;
        n0 = tx_done; irq0 = txirq_cnt;
        txq.push_back(tx_exp_t'{8'h11, 1'b0, 1'b0});
        load_tx(8'h11);
        held = 1'b1;
        for (int c = 0; c < 3 * bitc; c++) begin
            @(negedge clk);
            if (!txd) held = 1'b0;
        end
        chk(held, "R2 no start while disabled", held, 1);
        chk(tx_empty == 1'b0, "R2 buffer held", tx_empty, 0);
        tx_en = 1'b1;
        wait_tx(n0, irq0, 0);
        chk(txq.size() == 0, "R3 all characters sent", txq.size(), 0);
        summary();
    end
endmodule